// File: doc/BRIEF.md
# Backup Power Switchover and Seal Controller

This block decides where the RAM supply rail draws its power. It reads two comparator flags: the main supply is below the reset threshold, and the main supply is below the battery. From these it drives the enable of the main-supply switch and the enable of the battery switch. The battery takes over only when both flags are set. While the supply is only below the threshold but still above the battery, the main supply keeps feeding the rail.

It also holds a shipping seal that keeps a fresh battery off the rail until the product is first powered. The seal is armed by grounding the power-fail status pin during a reset timeout. The block reads that pin back at the midpoint and at the three-quarter point of the timeout, using the timeout count supplied by the reset stretcher. An armed seal takes effect at the next drop into backup. From then on the battery stays off the rail until the supply climbs back above the reset threshold.

The block also computes the level the power-fail status pin should be driven to. That level is forced high while the timeout runs, so that an externally grounded pin can be told apart from a driven low.

Top module: `bsw_ctrl`

## Requirements
- R1: While `sup_lo_thr` is 0, `out_from_main` is 1 and `out_from_batt` is 0, whatever `sup_lo_bat` is.
- R2: While `sup_lo_thr` is 1 and `sup_lo_bat` is 0, `out_from_main` is 1 and `out_from_batt` is 0.
- R3: While both `sup_lo_thr` and `sup_lo_bat` are 1 and no seal is armed or in effect, `out_from_batt` is 1 and `out_from_main` is 0.
- R4: `out_from_main` and `out_from_batt` are never 1 together.
- R5: The seal is armed when, during a timeout (`tmo_run`=1), `stat_pin` is 0 at the clock edge with `tmo_cnt` = TMO_LEN/2 and again at the edge with `tmo_cnt` = 3*TMO_LEN/4 (integer division). A later drop into backup then keeps `out_from_batt` at 0.
- R6: If `stat_pin` is 0 at only one of the two sample points, the seal is not armed and backup connects the battery.
- R7: If `mrst_n` is 0 at either sample point, the seal is not armed.
- R8: Once the seal is in effect, it stays in effect while `sup_lo_thr` remains 1. During that time `mrst_n` and `sup_lo_bat` changes do not release it. The first clock edge with `sup_lo_thr` = 0 releases it, and the next backup connects the battery.
- R9: While `tmo_run` is 1 and `sup_lo_bat` is 0, `stat_drive_hi` is 1 whatever `pf_lo` is.
- R10: While `sup_lo_bat` is 1, `stat_drive_hi` is 0. Otherwise, outside a timeout, `stat_drive_hi` is the inverse of `pf_lo`.
- R11: Both sample latches clear at the edge where `tmo_run` is 1 and `tmo_cnt` is 0. An armed seal is therefore dropped by a new timeout in which the pin reads high.
- R12: After reset, no seal is armed: the state with no inputs active gives main=1, batt=0, status=1, and an immediate backup connects the battery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_lo_thr | input | 1 | Main supply is below the reset threshold |
| sup_lo_bat | input | 1 | Main supply is below the battery voltage |
| tmo_run | input | 1 | Reset timeout is running |
| tmo_cnt | input | CNT_W (8) | Elapsed cycles in the reset timeout |
| stat_pin | input | 1 | Readback of the power-fail status pin |
| mrst_n | input | 1 | Manual reset, active low |
| pf_lo | input | 1 | Power-fail comparator input is below its threshold |
| out_from_main | output | 1 | Enable of the main-supply switch to the RAM rail |
| out_from_batt | output | 1 | Enable of the battery switch to the RAM rail |
| stat_drive_hi | output | 1 | Level to drive onto the power-fail status pin |

## Verification
A wrong arm or seal state has only one effect at the ports: a missing or unexpected battery enable. This is visible on the first cycle in which both supply flags are set, not while the supply is healthy. Sample-latch faults are therefore only seen after a full timeout followed by a backup entry. A wrong release of the seal shows at the second backup entry after the supply returns. The bench deliberately drives those sequences: an arming timeout, backup, threshold recovery, then backup again. Status-level faults show on the same cycle as the input change.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_BATT = 2'd2
  } src_e;

  // Clock-edge sample points inside the reset timeout
  function automatic int unsigned mid_point(input int unsigned len);
    return len / 2;
  endfunction

  function automatic int unsigned late_point(input int unsigned len);
    return (len * 3) / 4;
  endfunction

  // Power-fail status level: supply under battery wins, then timeout forcing
  function automatic logic stat_level(input logic lo_bat, input logic tmo,
                                      input logic pf);
    if (lo_bat) return 1'b0;
    if (tmo) return 1'b1;
    return ~pf;
  endfunction

endpackage

// File: rtl/bsw_path_sel.sv
module bsw_path_sel
  import bsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lo_thr,
  input  logic lo_bat,
  input  logic block_batt,
  output logic backup_req,
  output logic en_main,
  output logic en_batt
);
  src_e src;

  assign backup_req = lo_thr & lo_bat;

  always_comb begin
    if (!backup_req)     src = SRC_MAIN;
    else if (block_batt) src = SRC_NONE;
    else                 src = SRC_BATT;
  end

  assign en_main = (src == SRC_MAIN);
  assign en_batt = (src == SRC_BATT);

  p_one_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_main, en_batt}));

  p_above_thr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_thr |-> en_main && !en_batt);

  p_over_bat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_thr && !lo_bat |-> en_main);

  p_unsealed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_thr && lo_bat && !block_batt |-> en_batt);

endmodule

// File: rtl/bsw_seal.sv
module bsw_seal
  import bsw_pkg::*;
#(
  parameter int unsigned TMO_LEN = 200,
  parameter int unsigned CNT_W   = $clog2(TMO_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmo_run,
  input  logic [CNT_W-1:0] tmo_cnt,
  input  logic             stat_pin,
  input  logic             mrst_n,
  input  logic             lo_thr,
  input  logic             backup_req,
  output logic             block_batt
);
  localparam int unsigned MID  = mid_point(TMO_LEN);
  localparam int unsigned LATE = late_point(TMO_LEN);

  logic mid_q, arm_q, seal_q;

  // Named events for the checks below
  logic at_start, at_mid, at_late, pin_ok, release_ev, engage_ev;

  assign at_start   = tmo_run && (tmo_cnt == CNT_W'(0));
  assign at_mid     = tmo_run && (tmo_cnt == CNT_W'(MID));
  assign at_late    = tmo_run && (tmo_cnt == CNT_W'(LATE));
  assign pin_ok     = ~stat_pin & mrst_n;
  assign release_ev = seal_q & ~lo_thr;
  assign engage_ev  = arm_q & backup_req & ~seal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q  <= 1'b0;
      arm_q  <= 1'b0;
      seal_q <= 1'b0;
    end else begin
      if (at_start) begin
        mid_q <= 1'b0;
        arm_q <= 1'b0;
      end else begin
        if (at_mid)  mid_q <= pin_ok;
        if (at_late) arm_q <= mid_q & pin_ok;
      end
      if (release_ev) begin
        seal_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (engage_ev) begin
        seal_q <= 1'b1;
      end
    end
  end

  assign block_batt = arm_q | seal_q;

  p_arm_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |-> $past(mid_q) && !$past(stat_pin));

  p_arm_mr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |-> $past(mrst_n));

  p_seal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seal_q && lo_thr |=> seal_q);

  p_seal_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seal_q && !lo_thr |=> !seal_q && !arm_q);

  p_start_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    at_start |=> !arm_q && !mid_q);

endmodule

// File: rtl/bsw_status.sv
module bsw_status
  import bsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lo_bat,
  input  logic tmo_run,
  input  logic pf_lo,
  output logic stat_hi
);
  assign stat_hi = stat_level(lo_bat, tmo_run, pf_lo);

  p_tmo_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_run && !lo_bat |-> stat_hi);

  p_bat_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lo_bat |-> !stat_hi);

  p_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_bat && !tmo_run |-> stat_hi == !pf_lo);

endmodule

// File: rtl/bsw_ctrl.sv
module bsw_ctrl
  import bsw_pkg::*;
#(
  parameter int unsigned TMO_LEN = 200,
  parameter int unsigned CNT_W   = $clog2(TMO_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_lo_thr,
  input  logic             sup_lo_bat,
  input  logic             tmo_run,
  input  logic [CNT_W-1:0] tmo_cnt,
  input  logic             stat_pin,
  input  logic             mrst_n,
  input  logic             pf_lo,
  output logic             out_from_main,
  output logic             out_from_batt,
  output logic             stat_drive_hi
);
  logic backup_req, block_batt;

  bsw_path_sel u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_thr     (sup_lo_thr),
    .lo_bat     (sup_lo_bat),
    .block_batt (block_batt),
    .backup_req (backup_req),
    .en_main    (out_from_main),
    .en_batt    (out_from_batt)
  );

  bsw_seal #(.TMO_LEN(TMO_LEN), .CNT_W(CNT_W)) u_seal (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmo_run    (tmo_run),
    .tmo_cnt    (tmo_cnt),
    .stat_pin   (stat_pin),
    .mrst_n     (mrst_n),
    .lo_thr     (sup_lo_thr),
    .backup_req (backup_req),
    .block_batt (block_batt)
  );

  bsw_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_bat  (sup_lo_bat),
    .tmo_run (tmo_run),
    .pf_lo   (pf_lo),
    .stat_hi (stat_drive_hi)
  );

  p_top_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_from_main && out_from_batt));

endmodule

// File: tb/test_bsw_ctrl.sv
module test_bsw_ctrl;
  localparam int unsigned TMO  = 200;
  localparam int unsigned CW   = $clog2(TMO);
  localparam int unsigned HALF = TMO / 2;
  localparam int unsigned TQ   = (TMO * 3) / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_thr = 1'b0, lo_bat = 1'b0, trun = 1'b0, pin = 1'b1, mr_n = 1'b1, pf = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic o_main, o_batt, o_stat;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bsw_ctrl #(.TMO_LEN(TMO)) i_bsw_ctrl (
    .clk(clk), .rst_n(rst_n), .sup_lo_thr(lo_thr), .sup_lo_bat(lo_bat),
    .tmo_run(trun), .tmo_cnt(cnt), .stat_pin(pin), .mrst_n(mr_n), .pf_lo(pf),
    .out_from_main(o_main), .out_from_batt(o_batt), .stat_drive_hi(o_stat)
  );

  // {lo_thr, lo_bat, trun, pf} -> {main, batt, stat}
  localparam logic [6:0] VEC [10] = '{
    7'b0000_101, 7'b0001_100, 7'b0100_100, 7'b0010_101, 7'b0011_101,
    7'b1000_101, 7'b1001_100, 7'b1100_010, 7'b1101_010, 7'b0111_100
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic normal();
    @(negedge clk);
    lo_thr = 1'b0; lo_bat = 1'b0; trun = 1'b0; cnt = '0; pin = 1'b1; mr_n = 1'b1; pf = 1'b0;
  endtask

  // One full reset timeout; low_* selects pin low at each sample point,
  // mrlo_* pulls manual reset low at that point.
  task automatic run_tmo(input bit low_h, input bit low_q, input bit mrlo_h, input bit mrlo_q);
    for (int i = 0; i < int'(TMO); i++) begin
      @(negedge clk);
      trun = 1'b1;
      cnt  = CW'(i);
      pf   = 1'b1;
      pin  = (i == int'(HALF)) ? !low_h : (i == int'(TQ)) ? !low_q : 1'b1;
      mr_n = (i == int'(HALF)) ? !mrlo_h : (i == int'(TQ)) ? !mrlo_q : 1'b1;
      if (i == 5) begin
        #1;
        chk("R9 status forced high in timeout", o_stat, 1'b1);
      end
    end
    normal();
  endtask

  task automatic enter_backup();
    @(negedge clk);
    lo_thr = 1'b1; lo_bat = 1'b1;
    #1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12 reset main", o_main, 1'b1);
    chk("R12 reset batt", o_batt, 1'b0);
    chk("R12 reset stat", o_stat, 1'b1);
    enter_backup();
    chk("R12 backup after reset", o_batt, 1'b1);
    normal();

    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      {lo_thr, lo_bat, trun, pf} = VEC[k][6:3];
      cnt = CW'(3);
      #1;
      chk($sformatf("R1/R2/R3 vec%0d main", k), o_main, VEC[k][2]);
      chk($sformatf("R3/R4 vec%0d batt", k), o_batt, VEC[k][1]);
      chk($sformatf("R9/R10 vec%0d stat", k), o_stat, VEC[k][0]);
    end
    normal();

    // R5 arm, then R8 persistence and release
    run_tmo(1'b1, 1'b1, 1'b0, 1'b0);
    settle();
    chk("R1 main while armed", o_main, 1'b1);
    enter_backup();
    chk("R5 sealed batt", o_batt, 1'b0);
    chk("R5 sealed main", o_main, 1'b0);
    @(negedge clk); mr_n = 1'b0;
    settle();
    chk("R8 mr low batt", o_batt, 1'b0);
    @(negedge clk); mr_n = 1'b1; lo_bat = 1'b0;
    settle();
    chk("R8 over battery main", o_main, 1'b1);
    @(negedge clk); lo_bat = 1'b1;
    settle();
    chk("R8 still sealed batt", o_batt, 1'b0);
    @(negedge clk); lo_thr = 1'b0; lo_bat = 1'b0;
    enter_backup();
    chk("R8 released batt", o_batt, 1'b1);
    normal();

    run_tmo(1'b1, 1'b0, 1'b0, 1'b0);
    enter_backup();
    chk("R6 mid only batt", o_batt, 1'b1);
    normal();
    run_tmo(1'b0, 1'b1, 1'b0, 1'b0);
    enter_backup();
    chk("R6 late only batt", o_batt, 1'b1);
    normal();

    run_tmo(1'b1, 1'b1, 1'b1, 1'b0);
    enter_backup();
    chk("R7 mr low at mid batt", o_batt, 1'b1);
    normal();
    run_tmo(1'b1, 1'b1, 1'b0, 1'b1);
    enter_backup();
    chk("R7 mr low at late batt", o_batt, 1'b1);
    normal();

    run_tmo(1'b1, 1'b1, 1'b0, 1'b0);
    run_tmo(1'b0, 1'b0, 1'b0, 1'b0);
    enter_backup();
    chk("R11 rearm cleared batt", o_batt, 1'b1);
    chk("R10 backup stat low", o_stat, 1'b0);
    normal();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule